// File: doc/BRIEF.md
# Indexed Effective Address Unit

This unit evaluates load-effective-address operations for a processor core. It receives the second opcode byte, an 8-bit displacement, the current width mode, an optional width-override prefix and the present contents of the two index registers. From these it works out which index register is the base and which of five registers is the destination. It then forms base plus sign-extended displacement and presents a registered write request to the register file one clock after the request.

The sum is 24 bits wide in wide mode and 16 bits wide in narrow mode. A prefix can force either width regardless of the current mode. The unit never touches condition flags, so it has no flag port. Opcode bytes outside the defined set raise an illegal indication, and no write happens. The unit also reports the instruction's cycle cost, so the sequencer can account for the extra prefix byte.

Top module: `lea_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `wr_en`, `illegal`, `dst_sel` and `result` are all zero.
- R2: With index X as base, opcode 32h writes to X (dst 3) and 55h writes to Y (dst 4). Opcodes 02h, 12h and 22h write to pair 0, 1 and 2 (dst 0, 1, 2).
- R3: With index Y as base, opcode 54h writes to X (dst 3) and 33h writes to Y (dst 4). Opcodes 03h, 13h and 23h write to pair 0, 1 and 2 (dst 0, 1, 2).
- R4: The displacement is a two's-complement byte: 80h adds -128 and 7Fh adds +127.
- R5: In wide width the result is (base + displacement) modulo 2^24.
- R6: In narrow width the result is (base[15:0] + displacement) modulo 2^16, and result[23:16] is zero.
- R7: When `pfx_vld` is 1, `pfx_wide`=1 selects wide and `pfx_wide`=0 selects narrow, whatever `mode_wide` says. When `pfx_vld` is 0, `mode_wide`=1 selects wide.
- R8: Any other opcode gives `illegal`=1 and `wr_en`=0 in the response cycle. `result` and `dst_sel` keep their previous values, and the two flags are never high together.
- R9: Responses appear in the cycle after `req_vld` and last one cycle. In a cycle that follows no request, `wr_en` and `illegal` are 0.
- R10: `cyc_cost` in a response cycle is 3 without a prefix and 4 with one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request strobe for one operation |
| opcode | input | 8 | Second opcode byte |
| disp | input | 8 | Signed displacement |
| mode_wide | input | 1 | Current mode: 1 = 24-bit, 0 = 16-bit |
| pfx_vld | input | 1 | A width-override prefix preceded the opcode |
| pfx_wide | input | 1 | Prefix kind: 1 = long, 0 = short |
| idx_x | input | 24 | Current value of index X |
| idx_y | input | 24 | Current value of index Y |
| wr_en | output | 1 | Destination write strobe |
| dst_sel | output | 3 | Destination: 0..2 pairs, 3 X, 4 Y |
| result | output | 24 | Computed address |
| illegal | output | 1 | Undefined opcode seen |
| cyc_cost | output | 3 | Cycle cost of the operation |

## Verification
A wrong decode entry shows up in the single response cycle after the request. It appears either as the wrong `dst_sel` or as a sum taken from the other index register. Because the two index values in the tests differ widely, the value on `result` makes a wrong base plain. A bad width choice or a lost sign extension shows in the same cycle as a nonzero upper byte or an off-by-256 sum. A write or update leaking through on an undefined opcode shows as a changed `result` on the very next response.

// File: rtl/lea_pkg.sv
package lea_pkg;

    localparam int LEA_ADDR_W   = 24;
    localparam int LEA_NARROW_W = 16;
    localparam int LEA_DISP_W   = 8;
    localparam int LEA_OPC_W    = 8;
    localparam int LEA_COST_W   = 3;

    typedef enum logic [2:0] {
        DST_WP0 = 3'd0,
        DST_WP1 = 3'd1,
        DST_WP2 = 3'd2,
        DST_XR0 = 3'd3,
        DST_XR1 = 3'd4
    } dst_e;

    typedef enum logic {
        BASE_X = 1'b0,
        BASE_Y = 1'b1
    } base_e;

    typedef struct packed {
        logic  legal;
        base_e base;
        dst_e  dst;
    } dec_t;

    function automatic dec_t lea_decode_fn(input logic [LEA_OPC_W-1:0] op);
        dec_t d;
        d.legal = 1'b1;
        d.base  = BASE_X;
        d.dst   = DST_WP0;
        case (op)
            8'h02: begin d.base = BASE_X; d.dst = DST_WP0; end
            8'h12: begin d.base = BASE_X; d.dst = DST_WP1; end
            8'h22: begin d.base = BASE_X; d.dst = DST_WP2; end
            8'h32: begin d.base = BASE_X; d.dst = DST_XR0; end
            8'h55: begin d.base = BASE_X; d.dst = DST_XR1; end
            8'h03: begin d.base = BASE_Y; d.dst = DST_WP0; end
            8'h13: begin d.base = BASE_Y; d.dst = DST_WP1; end
            8'h23: begin d.base = BASE_Y; d.dst = DST_WP2; end
            8'h54: begin d.base = BASE_Y; d.dst = DST_XR0; end
            8'h33: begin d.base = BASE_Y; d.dst = DST_XR1; end
            default: d.legal = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/lea_decode.sv
module lea_decode
    import lea_pkg::*;
#(
    parameter int OPC_W = LEA_OPC_W
) (
    input  logic [OPC_W-1:0] opcode,
    output dec_t             dec
);
    always_comb begin
        dec = lea_decode_fn(opcode);
    end
endmodule

// File: rtl/lea_width.sv
module lea_width #(
    parameter int COST_W    = 3,
    parameter int BASE_COST = 3,
    parameter int PFX_COST  = 1
) (
    input  logic              mode_wide,
    input  logic              pfx_vld,
    input  logic              pfx_wide,
    output logic              narrow,
    output logic [COST_W-1:0] cost
);
    localparam logic [COST_W-1:0] COST_PLAIN = COST_W'(BASE_COST);
    localparam logic [COST_W-1:0] COST_PFX   = COST_W'(BASE_COST + PFX_COST);

    always_comb begin
        if (pfx_vld) begin
            narrow = ~pfx_wide;
            cost   = COST_PFX;
        end else begin
            narrow = ~mode_wide;
            cost   = COST_PLAIN;
        end
    end
endmodule

// File: rtl/lea_adder.sv
module lea_adder #(
    parameter int ADDR_W   = 24,
    parameter int NARROW_W = 16,
    parameter int DISP_W   = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    input  logic              narrow,
    output logic [ADDR_W-1:0] sum
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] sum_full;

    assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    assign sum_full = base + disp_ext;

    generate
        if (ADDR_W > NARROW_W) begin : g_masked
            localparam int HI_W = ADDR_W - NARROW_W;
            assign sum = narrow ? {{HI_W{1'b0}}, sum_full[NARROW_W-1:0]} : sum_full;
        end else begin : g_plain
            logic unused_narrow;
            assign unused_narrow = narrow;
            assign sum = sum_full;
        end
    endgenerate
endmodule

// File: rtl/lea_unit.sv
module lea_unit
    import lea_pkg::*;
#(
    parameter int ADDR_W    = LEA_ADDR_W,
    parameter int NARROW_W  = LEA_NARROW_W,
    parameter int DISP_W    = LEA_DISP_W,
    parameter int OPC_W     = LEA_OPC_W,
    parameter int COST_W    = LEA_COST_W,
    parameter int BASE_COST = 3,
    parameter int PFX_COST  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_vld,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DISP_W-1:0] disp,
    input  logic              mode_wide,
    input  logic              pfx_vld,
    input  logic              pfx_wide,
    input  logic [ADDR_W-1:0] idx_x,
    input  logic [ADDR_W-1:0] idx_y,
    output logic              wr_en,
    output logic [2:0]        dst_sel,
    output logic [ADDR_W-1:0] result,
    output logic              illegal,
    output logic [COST_W-1:0] cyc_cost
);
    dec_t              dec;
    logic              narrow;
    logic [COST_W-1:0] cost;
    logic [ADDR_W-1:0] base_val;
    logic [ADDR_W-1:0] sum;

    lea_decode #(.OPC_W(OPC_W)) u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    lea_width #(
        .COST_W    (COST_W),
        .BASE_COST (BASE_COST),
        .PFX_COST  (PFX_COST)
    ) u_width (
        .mode_wide (mode_wide),
        .pfx_vld   (pfx_vld),
        .pfx_wide  (pfx_wide),
        .narrow    (narrow),
        .cost      (cost)
    );

    assign base_val = (dec.base == BASE_Y) ? idx_y : idx_x;

    lea_adder #(
        .ADDR_W   (ADDR_W),
        .NARROW_W (NARROW_W),
        .DISP_W   (DISP_W)
    ) u_add (
        .base   (base_val),
        .disp   (disp),
        .narrow (narrow),
        .sum    (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en    <= 1'b0;
            illegal  <= 1'b0;
            dst_sel  <= '0;
            result   <= '0;
            cyc_cost <= '0;
        end else if (req_vld) begin
            wr_en    <= dec.legal;
            illegal  <= ~dec.legal;
            cyc_cost <= cost;
            if (dec.legal) begin
                dst_sel <= dec.dst;
                result  <= sum;
            end
        end else begin
            wr_en   <= 1'b0;
            illegal <= 1'b0;
        end
    end
endmodule

// File: rtl/lea_unit_chk.sv
module lea_unit_chk #(
    parameter int ADDR_W   = 24,
    parameter int NARROW_W = 16,
    parameter int COST_W   = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req_vld,
    input logic              mode_wide,
    input logic              pfx_vld,
    input logic              pfx_wide,
    input logic              wr_en,
    input logic [2:0]        dst_sel,
    input logic [ADDR_W-1:0] result,
    input logic              illegal,
    input logic [COST_W-1:0] cyc_cost
);
    logic narrow_req;
    assign narrow_req = pfx_vld ? ~pfx_wide : ~mode_wide;

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && illegal));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        illegal |-> ($stable(result) && $stable(dst_sel)));

    assert_after_req_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en || illegal) |-> $past(req_vld));

    assert_dst_range_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (dst_sel <= 3'd4));

    assert_narrow_upper_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(narrow_req)) |-> (result[ADDR_W-1:NARROW_W] == '0));

    assert_cost_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en || illegal) |-> (cyc_cost == ($past(pfx_vld) ? COST_W'(4) : COST_W'(3))));
endmodule

bind lea_unit lea_unit_chk #(
    .ADDR_W   (ADDR_W),
    .NARROW_W (NARROW_W),
    .COST_W   (COST_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_vld   (req_vld),
    .mode_wide (mode_wide),
    .pfx_vld   (pfx_vld),
    .pfx_wide  (pfx_wide),
    .wr_en     (wr_en),
    .dst_sel   (dst_sel),
    .result    (result),
    .illegal   (illegal),
    .cyc_cost  (cyc_cost)
);

// File: tb/tb_lea_unit.sv
module tb_lea_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_vld = 1'b0;
    logic [7:0]  opcode = '0;
    logic [7:0]  disp = '0;
    logic        mode_wide = 1'b1;
    logic        pfx_vld = 1'b0;
    logic        pfx_wide = 1'b0;
    logic [23:0] idx_x = 24'h102030;
    logic [23:0] idx_y = 24'hA05070;
    logic        wr_en;
    logic [2:0]  dst_sel;
    logic [23:0] result;
    logic        illegal;
    logic [2:0]  cyc_cost;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lea_unit dut (
        .clk(clk), .rst(rst), .req_vld(req_vld), .opcode(opcode), .disp(disp),
        .mode_wide(mode_wide), .pfx_vld(pfx_vld), .pfx_wide(pfx_wide),
        .idx_x(idx_x), .idx_y(idx_y), .wr_en(wr_en), .dst_sel(dst_sel),
        .result(result), .illegal(illegal), .cyc_cost(cyc_cost)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] model_sum(input logic [7:0] op, input logic [7:0] d,
                                               input logic mw, input logic pv, input logic pw);
        logic [23:0] b;
        logic [23:0] s;
        logic        nar;
        b   = (op == 8'h03 || op == 8'h13 || op == 8'h23 || op == 8'h54 || op == 8'h33) ? idx_y : idx_x;
        nar = pv ? !pw : !mw;
        s   = b + {{16{d[7]}}, d};
        if (nar) s = {8'h00, s[15:0]};
        return s;
    endfunction

    function automatic logic [2:0] model_dst(input logic [7:0] op);
        case (op)
            8'h02, 8'h03: return 3'd0;
            8'h12, 8'h13: return 3'd1;
            8'h22, 8'h23: return 3'd2;
            8'h32, 8'h54: return 3'd3;
            default:      return 3'd4;
        endcase
    endfunction

    task automatic apply(input logic [7:0] op, input logic [7:0] d,
                         input logic mw, input logic pv, input logic pw);
        @(negedge clk);
        opcode = op; disp = d; mode_wide = mw; pfx_vld = pv; pfx_wide = pw;
        req_vld = 1'b1;
        @(negedge clk);
        req_vld = 1'b0;
    endtask

    task automatic expect_write(input string tag, input logic [7:0] op, input logic [7:0] d,
                                input logic mw, input logic pv, input logic pw);
        apply(op, d, mw, pv, pw);
        check({tag, " wr_en"},   32'(wr_en),   32'd1);
        check({tag, " illegal"}, 32'(illegal), 32'd0);
        check({tag, " dst"},     32'(dst_sel), 32'(model_dst(op)));
        check({tag, " result"},  32'(result),  32'(model_sum(op, d, mw, pv, pw)));
    endtask

    task automatic t_reset();
        check("R1 wr_en",   32'(wr_en),   32'd0);
        check("R1 illegal", 32'(illegal), 32'd0);
        check("R1 dst",     32'(dst_sel), 32'd0);
        check("R1 result",  32'(result),  32'd0);
    endtask

    task automatic t_x_base();
        expect_write("R2 op02", 8'h02, 8'h05, 1'b1, 1'b0, 1'b0);
        expect_write("R2 op12", 8'h12, 8'h10, 1'b1, 1'b0, 1'b0);
        expect_write("R2 op22", 8'h22, 8'hF0, 1'b1, 1'b0, 1'b0);
        expect_write("R2 op32", 8'h32, 8'h01, 1'b1, 1'b0, 1'b0);
        expect_write("R2 op55", 8'h55, 8'h7E, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_y_base();
        expect_write("R3 op03", 8'h03, 8'h05, 1'b1, 1'b0, 1'b0);
        expect_write("R3 op13", 8'h13, 8'h10, 1'b1, 1'b0, 1'b0);
        expect_write("R3 op23", 8'h23, 8'hF0, 1'b1, 1'b0, 1'b0);
        expect_write("R3 op54", 8'h54, 8'h01, 1'b1, 1'b0, 1'b0);
        expect_write("R3 op33", 8'h33, 8'h7E, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_disp_sign();
        apply(8'h02, 8'h80, 1'b1, 1'b0, 1'b0);
        check("R4 minus128", 32'(result), 32'(24'h102030 - 24'd128));
        apply(8'h02, 8'h7F, 1'b1, 1'b0, 1'b0);
        check("R4 plus127", 32'(result), 32'(24'h102030 + 24'd127));
    endtask

    task automatic t_wide_wrap();
        idx_x = 24'hFFFFF0;
        apply(8'h32, 8'h20, 1'b1, 1'b0, 1'b0);
        check("R5 wrap up", 32'(result), 32'h000010);
        idx_x = 24'h000005;
        apply(8'h12, 8'hF0, 1'b1, 1'b0, 1'b0);
        check("R5 wrap down", 32'(result), 32'hFFFFF5);
        idx_x = 24'h102030;
    endtask

    task automatic t_narrow();
        idx_y = 24'h12FFF0;
        apply(8'h33, 8'h20, 1'b0, 1'b0, 1'b0);
        check("R6 narrow wrap", 32'(result), 32'h000010);
        idx_y = 24'h340004;
        apply(8'h23, 8'hF8, 1'b0, 1'b0, 1'b0);
        check("R6 narrow borrow", 32'(result), 32'h00FFFC);
        idx_y = 24'hA05070;
    endtask

    task automatic t_prefix();
        apply(8'h03, 8'h10, 1'b0, 1'b1, 1'b1);
        check("R7 long in narrow", 32'(result), 32'hA05080);
        apply(8'h03, 8'h10, 1'b1, 1'b1, 1'b0);
        check("R7 short in wide", 32'(result), 32'h005080);
        expect_write("R7 mix", 8'h55, 8'h80, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_illegal();
        logic [23:0] prev_res;
        logic [2:0]  prev_dst;
        apply(8'h22, 8'h11, 1'b1, 1'b0, 1'b0);
        prev_res = result;
        prev_dst = dst_sel;
        foreach (prev_res[i]) begin end
        apply(8'h42, 8'h33, 1'b1, 1'b0, 1'b0);
        check("R8 illegal flag", 32'(illegal), 32'd1);
        check("R8 no write",     32'(wr_en),   32'd0);
        check("R8 result held",  32'(result),  32'(prev_res));
        check("R8 dst held",     32'(dst_sel), 32'(prev_dst));
        apply(8'h00, 8'h01, 1'b1, 1'b0, 1'b0);
        check("R8 op00", 32'(illegal), 32'd1);
        apply(8'hFF, 8'h01, 1'b0, 1'b1, 1'b0);
        check("R8 opFF", 32'(wr_en), 32'd0);
        check("R8 opFF result", 32'(result), 32'(prev_res));
    endtask

    task automatic t_idle();
        apply(8'h13, 8'h02, 1'b1, 1'b0, 1'b0);
        check("R9 pulse", 32'(wr_en), 32'd1);
        @(negedge clk);
        check("R9 idle wr_en",   32'(wr_en),   32'd0);
        check("R9 idle illegal", 32'(illegal), 32'd0);
        apply(8'h77, 8'h02, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check("R9 illegal pulse", 32'(illegal), 32'd0);
    endtask

    task automatic t_cost();
        apply(8'h02, 8'h00, 1'b1, 1'b0, 1'b0);
        check("R10 plain", 32'(cyc_cost), 32'd3);
        apply(8'h02, 8'h00, 1'b1, 1'b1, 1'b0);
        check("R10 prefixed", 32'(cyc_cost), 32'd4);
        apply(8'h99, 8'h00, 1'b1, 1'b1, 1'b1);
        check("R10 illegal prefixed", 32'(cyc_cost), 32'd4);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_x_base();
        t_y_base();
        t_disp_sign();
        t_wide_wrap();
        t_narrow();
        t_prefix();
        t_illegal();
        t_idle();
        t_cost();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        #(5.0 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule